// File: doc/BRIEF.md
# USART Host Register Interface and Mode Sequencer

This block is the host side of a programmable serial controller. A host reaches it through a chip select, a control/data select line, and single-cycle read and write strobes. It turns those accesses into register updates and into transfers to and from the transmit and receive buffers. The serial shifting is done by separate transmitter and receiver blocks. This block gives them their configuration and enables, and it collects their flags for the host.

There is one control address, and two write registers share it. A small sequencer tells them apart by write order. After any reset, the first control write sets the character format, and that format is locked from then on. Every later control write is a command word. A command word can enable the transmitter or the receiver, pulse an error-flag clear, or request an internal reset. The internal reset returns the sequencer to waiting for a new format word. A read of the control address returns a status byte. The data address writes into the transmit buffer and reads from the receive buffer.

All outputs are registered. Reset is synchronous and active high.

Top module: `sio_host_regs`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `mode_loaded`, `tx_en`, `rx_en`, `tx_load`, `rx_take` and `err_clear` are 0, every format output is 0, and `rdata` is 0.
- R2: The first control write after any reset (`sel`=1, `ctl_sel`=1, `wr_stb`=1) loads the format word. Its fields are:
  - bits 1:0 go to `clk_factor`;
  - bits 3:2 go to `char_len`;
  - bit 4 goes to `parity_en`;
  - bit 5 goes to `parity_even`;
  - bits 7:6 go to `stop_sel`.

  The write also sets `mode_loaded` one clock edge later. Writing CAh gives `clk_factor`=2, `char_len`=2, `parity_en`=0, `stop_sel`=3.
- R3: Once `mode_loaded` is 1, control writes never change the format outputs, whatever value they carry.
- R4: A command write without bit 6 set loads the enables: bit 0 goes to `tx_en` and bit 2 goes to `rx_en`. The value 11h gives `tx_en`=1 and `rx_en`=0.
- R5: A command write with bit 4 set drives `err_clear` high for exactly one cycle after the write edge. The bit is not held.
- R6: A command write with bit 6 set clears the format outputs, `tx_en`, `rx_en` and `mode_loaded`. The next control write is then taken as a format word. Bit 6 of a format word has no reset effect.
- R7: A control read returns this status byte in `rdata` one cycle after the strobe:
  - bit 0 is `tx_ready`;
  - bit 1 is `rx_ready`;
  - bit 2 is `tx_empty`;
  - bit 3 is `err_parity`;
  - bit 4 is `err_overrun`;
  - bit 5 is `err_framing`;
  - bits 7:6 are 0.
- R8: A data write (`ctl_sel`=0) puts `wdata` on `tx_byte` and pulses `tx_load` for one cycle after the edge. Control writes never pulse `tx_load`.
- R9: A data read returns `rx_byte` in `rdata` and pulses `rx_take` for one cycle after the edge.
- R10: With `sel`=0, strobes have no effect on registers, enables, pulses or `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip select |
| ctl_sel | input | 1 | 1 selects the control/status address, 0 the data address |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wdata | input | DW | Write data from the host |
| rdata | output | DW | Registered read data to the host |
| tx_ready | input | 1 | Transmit buffer can accept a byte |
| tx_empty | input | 1 | Transmit shifter is idle |
| rx_ready | input | 1 | Receive buffer holds a byte |
| rx_byte | input | DW | Receive buffer contents |
| err_parity | input | 1 | Parity error flag |
| err_overrun | input | 1 | Overrun error flag |
| err_framing | input | 1 | Framing error flag |
| tx_byte | output | DW | Byte for the transmit buffer |
| tx_load | output | 1 | Load pulse for the transmit buffer |
| rx_take | output | 1 | Receive buffer consumed pulse |
| err_clear | output | 1 | One-cycle error-flag clear |
| clk_factor | output | 2 | Bit clock factor select |
| char_len | output | 2 | Character length select |
| parity_en | output | 1 | Parity enable |
| parity_even | output | 1 | Parity sense |
| stop_sel | output | 2 | Stop bit select |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| mode_loaded | output | 1 | Format word accepted; control writes are commands |

## Verification
The riskiest internal state is the sequencer phase, and a wrong phase never stays hidden. Suppose the sequencer believes a format is loaded when it is not. The very next control write then reaches the enables instead of the format outputs, so the format outputs keep their old values one edge after a write that should have changed them. Suppose instead it believes it is still waiting for a format. Then a command overwrites the format outputs on the edge after the write. The tests therefore follow every control write with an immediate check of both the format outputs and the enables. They also probe a format word carrying bit 6 and a command carrying format-like bit patterns.

// File: rtl/sio_host_pkg.sv
package sio_host_pkg;
  typedef enum logic {
    SEQ_WANT_MODE = 1'b0,
    SEQ_WANT_CMD  = 1'b1
  } seq_state_t;

  typedef struct packed {
    logic [1:0] stop_sel;
    logic       parity_even;
    logic       parity_en;
    logic [1:0] char_len;
    logic [1:0] clk_factor;
  } fmt_word_t;

  localparam int CTL_W       = 8;
  localparam int CMD_TX_BIT  = 0;
  localparam int CMD_RX_BIT  = 2;
  localparam int CMD_ERR_BIT = 4;
  localparam int CMD_RST_BIT = 6;
endpackage

// File: rtl/sio_access_decode.sv
module sio_access_decode (
  input  logic sel,
  input  logic ctl_sel,
  input  logic wr_stb,
  input  logic rd_stb,
  output logic ctl_wr,
  output logic ctl_rd,
  output logic dat_wr,
  output logic dat_rd
);
  logic wr_hit, rd_hit;

  always_comb begin
    wr_hit = sel & wr_stb;
    rd_hit = sel & rd_stb & ~wr_stb;
    ctl_wr = wr_hit & ctl_sel;
    dat_wr = wr_hit & ~ctl_sel;
    ctl_rd = rd_hit & ctl_sel;
    dat_rd = rd_hit & ~ctl_sel;
  end
endmodule

// File: rtl/sio_mode_seq.sv
module sio_mode_seq
  import sio_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] wdata,
  output fmt_word_t        fmt,
  output logic             tx_en,
  output logic             rx_en,
  output logic             err_clear,
  output logic             mode_loaded
);
  seq_state_t state;
  logic       soft_rst;

  assign soft_rst    = ctl_wr && (state == SEQ_WANT_CMD) && wdata[CMD_RST_BIT];
  assign mode_loaded = (state == SEQ_WANT_CMD);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      state     <= SEQ_WANT_MODE;
      fmt       <= '0;
      tx_en     <= 1'b0;
      rx_en     <= 1'b0;
      err_clear <= 1'b0;
    end else begin
      err_clear <= 1'b0;
      if (ctl_wr) begin
        if (state == SEQ_WANT_MODE) begin
          fmt   <= fmt_word_t'(wdata);
          state <= SEQ_WANT_CMD;
        end else begin
          tx_en     <= wdata[CMD_TX_BIT];
          rx_en     <= wdata[CMD_RX_BIT];
          err_clear <= wdata[CMD_ERR_BIT];
        end
      end
    end
  end
endmodule

// File: rtl/sio_data_port.sv
module sio_data_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_rd,
  input  logic          dat_rd,
  input  logic          dat_wr,
  input  logic [DW-1:0] wdata,
  input  logic [5:0]    status,
  input  logic [DW-1:0] rx_byte,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] tx_byte,
  output logic          tx_load,
  output logic          rx_take
);
  localparam int ST_W = 6;

  logic [DW-1:0] status_ext;

  always_comb begin
    status_ext = '0;
    status_ext[ST_W-1:0] = status;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      tx_byte <= '0;
      tx_load <= 1'b0;
      rx_take <= 1'b0;
    end else begin
      tx_load <= dat_wr;
      rx_take <= dat_rd;
      if (dat_wr) tx_byte <= wdata;
      if (ctl_rd)      rdata <= status_ext;
      else if (dat_rd) rdata <= rx_byte;
    end
  end
endmodule

// File: rtl/sio_host_regs.sv
module sio_host_regs
  import sio_host_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          ctl_sel,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          tx_ready,
  input  logic          tx_empty,
  input  logic          rx_ready,
  input  logic [DW-1:0] rx_byte,
  input  logic          err_parity,
  input  logic          err_overrun,
  input  logic          err_framing,
  output logic [DW-1:0] tx_byte,
  output logic          tx_load,
  output logic          rx_take,
  output logic          err_clear,
  output logic [1:0]    clk_factor,
  output logic [1:0]    char_len,
  output logic          parity_en,
  output logic          parity_even,
  output logic [1:0]    stop_sel,
  output logic          tx_en,
  output logic          rx_en,
  output logic          mode_loaded
);
  logic      ctl_wr, ctl_rd, dat_wr, dat_rd;
  fmt_word_t fmt;
  logic [5:0] status;

  sio_access_decode u_dec (
    .sel(sel), .ctl_sel(ctl_sel), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .dat_wr(dat_wr), .dat_rd(dat_rd)
  );

  sio_mode_seq u_seq (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .wdata(wdata[CTL_W-1:0]),
    .fmt(fmt), .tx_en(tx_en), .rx_en(rx_en), .err_clear(err_clear),
    .mode_loaded(mode_loaded)
  );

  assign status = {err_framing, err_overrun, err_parity, tx_empty, rx_ready, tx_ready};

  sio_data_port #(.DW(DW)) u_dat (
    .clk(clk), .rst(rst), .ctl_rd(ctl_rd), .dat_rd(dat_rd), .dat_wr(dat_wr),
    .wdata(wdata), .status(status), .rx_byte(rx_byte), .rdata(rdata),
    .tx_byte(tx_byte), .tx_load(tx_load), .rx_take(rx_take)
  );

  assign clk_factor  = fmt.clk_factor;
  assign char_len    = fmt.char_len;
  assign parity_en   = fmt.parity_en;
  assign parity_even = fmt.parity_even;
  assign stop_sel    = fmt.stop_sel;
endmodule

// File: rtl/sio_host_regs_chk.sv
module sio_host_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       sel,
  input logic       ctl_sel,
  input logic       wr_stb,
  input logic       rd_stb,
  input logic       tx_load,
  input logic       rx_take,
  input logic       err_clear,
  input logic [1:0] clk_factor,
  input logic [1:0] char_len,
  input logic       parity_en,
  input logic       parity_even,
  input logic [1:0] stop_sel,
  input logic       tx_en,
  input logic       rx_en,
  input logic       mode_loaded
);
  // R1: cleared state right after reset
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mode_loaded && !tx_en && !rx_en && !tx_load && !rx_take && !err_clear));

  // R3: format locked while the sequencer stays in command phase
  assert_fmt_locked_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_loaded && $past(mode_loaded)) |->
      $stable({clk_factor, char_len, parity_en, parity_even, stop_sel}));

  // R5: error clear never lasts two cycles
  assert_err_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    err_clear |=> !err_clear);

  // R8: transmit load only follows a selected data write
  assert_tx_load_src_R8: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> $past(sel && wr_stb && !ctl_sel));

  // R9: receive take only follows a selected data read
  assert_rx_take_src_R9: assert property (@(posedge clk) disable iff (rst)
    rx_take |-> $past(sel && rd_stb && !ctl_sel));

  // R10: no pulse after a deselected cycle
  assert_deselect_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(sel) |-> (!tx_load && !rx_take && !err_clear));
endmodule

bind sio_host_regs sio_host_regs_chk u_chk (
  .clk(clk), .rst(rst), .sel(sel), .ctl_sel(ctl_sel), .wr_stb(wr_stb),
  .rd_stb(rd_stb), .tx_load(tx_load), .rx_take(rx_take), .err_clear(err_clear),
  .clk_factor(clk_factor), .char_len(char_len), .parity_en(parity_en),
  .parity_even(parity_even), .stop_sel(stop_sel), .tx_en(tx_en), .rx_en(rx_en),
  .mode_loaded(mode_loaded)
);

// File: tb/sio_host_regs_test.sv
module sio_host_regs_test;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0, ctl_sel = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic tx_ready = 1'b0, tx_empty = 1'b0, rx_ready = 1'b0;
  logic [DW-1:0] rx_byte = '0;
  logic err_parity = 1'b0, err_overrun = 1'b0, err_framing = 1'b0;
  logic [DW-1:0] tx_byte;
  logic tx_load, rx_take, err_clear;
  logic [1:0] clk_factor, char_len, stop_sel;
  logic parity_en, parity_even, tx_en, rx_en, mode_loaded;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sio_host_regs #(.DW(DW)) uut (
    .clk(clk), .rst(rst), .sel(sel), .ctl_sel(ctl_sel), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .wdata(wdata), .rdata(rdata), .tx_ready(tx_ready),
    .tx_empty(tx_empty), .rx_ready(rx_ready), .rx_byte(rx_byte),
    .err_parity(err_parity), .err_overrun(err_overrun), .err_framing(err_framing),
    .tx_byte(tx_byte), .tx_load(tx_load), .rx_take(rx_take), .err_clear(err_clear),
    .clk_factor(clk_factor), .char_len(char_len), .parity_en(parity_en),
    .parity_even(parity_even), .stop_sel(stop_sel), .tx_en(tx_en), .rx_en(rx_en),
    .mode_loaded(mode_loaded)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic fmt_is(input string req, input logic [7:0] w);
    chk(req, "format", {stop_sel, parity_even, parity_en, char_len, clk_factor}, {24'd0, w});
  endtask

  // one-cycle bus access; returns at the negedge after the active edge
  task automatic access(input logic s, input logic c, input logic w, input logic [7:0] d);
    @(negedge clk);
    sel = s; ctl_sel = c; wr_stb = w; rd_stb = ~w; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "mode_loaded", mode_loaded, 0);
    chk("R1", "enables", {tx_en, rx_en}, 0);
    chk("R1", "pulses", {tx_load, rx_take, err_clear}, 0);
    chk("R1", "rdata", rdata, 0);
    fmt_is("R1", 8'h00);
  endtask

  task automatic t_mode_then_cmd();
    access(1, 1, 1, 8'hCA);
    fmt_is("R2", 8'hCA);
    chk("R2", "clk_factor", clk_factor, 2);
    chk("R2", "stop_sel", stop_sel, 3);
    chk("R2", "mode_loaded", mode_loaded, 1);
    chk("R2", "enables untouched", {tx_en, rx_en}, 0);
    access(1, 1, 1, 8'h11);
    chk("R4", "tx_en", tx_en, 1);
    chk("R4", "rx_en", rx_en, 0);
    chk("R5", "err_clear high", err_clear, 1);
    fmt_is("R3", 8'hCA);
    @(negedge clk);
    chk("R5", "err_clear one cycle", err_clear, 0);
    access(1, 1, 1, 8'hBD);
    chk("R4", "enables BD", {tx_en, rx_en}, 2'b11);
    fmt_is("R3", 8'hCA);
    access(1, 1, 1, 8'h04);
    chk("R4", "enables 04", {tx_en, rx_en}, 2'b01);
    chk("R5", "no clear without bit4", err_clear, 0);
    chk("R8", "no tx_load on control", tx_load, 0);
  endtask

  task automatic t_internal_reset();
    access(1, 1, 1, 8'h41);
    chk("R6", "mode_loaded", mode_loaded, 0);
    chk("R6", "enables", {tx_en, rx_en}, 0);
    fmt_is("R6", 8'h00);
    access(1, 1, 1, 8'h7D);
    fmt_is("R6", 8'h7D);
    chk("R6", "format bit6 no reset", mode_loaded, 1);
    chk("R6", "format D0 not enable", tx_en, 0);
    access(1, 1, 1, 8'h01);
    chk("R6", "command after reformat", tx_en, 1);
    fmt_is("R3", 8'h7D);
  endtask

  task automatic t_status();
    tx_ready = 1; rx_ready = 0; tx_empty = 1; err_parity = 0; err_overrun = 1; err_framing = 0;
    access(1, 1, 0, 8'h00);
    chk("R7", "status 15", rdata, 8'h15);
    tx_ready = 0; rx_ready = 1; tx_empty = 0; err_parity = 1; err_overrun = 0; err_framing = 1;
    access(1, 1, 0, 8'h00);
    chk("R7", "status 2A", rdata, 8'h2A);
    chk("R9", "no rx_take on status", rx_take, 0);
  endtask

  task automatic t_data();
    access(1, 0, 1, 8'hA5);
    chk("R8", "tx_load", tx_load, 1);
    chk("R8", "tx_byte", tx_byte, 8'hA5);
    @(negedge clk);
    chk("R8", "tx_load one cycle", tx_load, 0);
    rx_byte = 8'h5C;
    access(1, 0, 0, 8'h00);
    chk("R9", "rdata", rdata, 8'h5C);
    chk("R9", "rx_take", rx_take, 1);
    @(negedge clk);
    chk("R9", "rx_take one cycle", rx_take, 0);
  endtask

  task automatic t_deselect();
    rx_byte = 8'h33;
    access(0, 1, 1, 8'h40);
    chk("R10", "no soft reset", mode_loaded, 1);
    chk("R10", "tx_en kept", tx_en, 1);
    access(0, 0, 1, 8'h99);
    chk("R10", "no tx_load", tx_load, 0);
    chk("R10", "tx_byte kept", tx_byte, 8'hA5);
    access(0, 0, 0, 8'h00);
    chk("R10", "rdata kept", rdata, 8'h5C);
    chk("R10", "no rx_take", rx_take, 0);
  endtask

  task automatic t_ext_reset();
    do_reset();
    chk("R1", "ext reset mode_loaded", mode_loaded, 0);
    chk("R1", "ext reset enables", {tx_en, rx_en}, 0);
    fmt_is("R1", 8'h00);
    access(1, 1, 1, 8'h4E);
    fmt_is("R2", 8'h4E);
    chk("R2", "loaded after ext reset", mode_loaded, 1);
  endtask

  initial begin
    t_reset();
    t_mode_then_cmd();
    t_internal_reset();
    t_status();
    t_data();
    t_deselect();
    t_ext_reset();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule